// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Wakeup

This block gathers five interrupt sources and turns them into a high-priority request, a low-priority request and a wakeup signal for a processor core. Three of the sources are external pins with selectable edge polarity. One is a timer wrap event that can be 8 bits or 16 bits wide. The last is a change on a 4-bit input port. Every source has a sticky flag and an enable bit. Every source except external pin 0 also has a priority bit. External pin 0 is always high priority.

Software controls the block through a small register port. A register write replaces the flags that the addressed register holds, so writing 0 clears a flag and writing 1 sets one. A hardware event that arrives in the same cycle as the write still sets its flag. The pins and the port pass through a two-flop synchroniser before edge or change detection. The port-change logic compares the synchronised port against a snapshot, and the snapshot is refreshed each time the port register is read.

The core reports two conditions to the block: that it is asleep, and that a high-priority service is running. The wakeup output does not depend on the global enables. The request outputs do depend on them.

Top module: `prio_irq_ctrl`

## Requirements
- R1: External pin n detects a rising edge when its edge-select bit is 1 and a falling edge when that bit is 0. The edge-select bits sit at register 1, bits 4, 5 and 6 for pins 0, 1 and 2. The opposite edge has no effect. A valid edge shows in the flag after the third rising clock edge that follows the pin change, and the flag is still clear after the second.
- R2: Flags are sticky. Hardware never clears a flag. A register write loads each flag in the addressed register from the write data, so 0 clears the flag and 1 sets it.
- R3: When a flag-clearing write and a new event for that flag fall in the same cycle, the flag is left set.
- R4: A flag whose enable bit is clear is still recorded. It raises no request and no wakeup.
- R5: External pin 0 has no priority bit. With its enable (register 0, bit 4), its flag (register 0, bit 1) and the global high enable (register 0, bit 7) all set, irq_hi is asserted. This source never drives irq_lo.
- R6: Pins 1 and 2 use priority bits at register 2, bit 6 and bit 7 (1 means high, 0 means low). Their enables are at register 2, bits 3 and 4. Their flags are at register 2, bits 0 and 1.
- R7: The timer flag (register 0, bit 2) is set by tmr_wrap8 when tmr_wide is 0 and by tmr_wrap16 when tmr_wide is 1. The input that is not selected is ignored. The flag is visible after one clock edge. The timer enable is register 0, bit 5 and its priority is register 1, bit 2.
- R8: The port-change flag (register 0, bit 0) is set whenever the synchronised port_in differs from the snapshot. Reading register 3 returns the synchronised port in bits 7:4, with bits 3:0 reading 0, and copies it into the snapshot. The port enable is register 0, bit 3 and its priority is register 1, bit 0.
- R9: irq_lo requires the global high enable (register 0, bit 7), the low enable (register 0, bit 6) and hp_active low. irq_hi requires the global high enable.
- R10: wake is asserted when sleeping is 1 and any source has both its flag and its enable set, whatever the global enables are. wake is 0 while sleeping is 0.
- R11: After reset every register reads 0, and irq_hi, irq_lo and wake are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 3 | External interrupt pins, asynchronous |
| port_in | input | PORT_W (4) | Change-detect port inputs, asynchronous |
| tmr_wrap8 | input | 1 | One-cycle pulse when the timer wraps in 8-bit mode |
| tmr_wrap16 | input | 1 | One-cycle pulse when the timer wraps in 16-bit mode |
| tmr_wide | input | 1 | Timer mode: 1 selects the 16-bit wrap |
| sleeping | input | 1 | Core is in sleep |
| hp_active | input | 1 | High-priority service in progress |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; only matters for register 3 |
| reg_addr | input | 2 | Register address 0..3 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| irq_hi | output | 1 | High-priority request |
| irq_lo | output | 1 | Low-priority request |
| wake | output | 1 | Wakeup request |

## Verification
A pin or port change sits in the synchroniser for two edges and is detected on the third. Writes and timer pulses take effect on the next edge. The requests and wake follow the flags, sleeping and hp_active within the same cycle. The bench drives every input on a falling edge and counts the rising edges each result needs. It samples a little after the following falling edge, and for pin edges it also confirms that the flag is still clear one edge too early.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int EXT_N  = 3;
  localparam int SRC_N  = 5;
  localparam int REG_AW = 2;
  localparam int REG_DW = 8;

  // source slots in the flag / enable / priority vectors
  localparam int SRC_PORT = 0;
  localparam int SRC_TMR  = 1;
  localparam int SRC_X0   = 2;
  localparam int SRC_X1   = 3;
  localparam int SRC_X2   = 4;

  localparam logic [REG_AW-1:0] A_MAIN = 2'd0;
  localparam logic [REG_AW-1:0] A_CFG  = 2'd1;
  localparam logic [REG_AW-1:0] A_EXT  = 2'd2;
  localparam logic [REG_AW-1:0] A_PORT = 2'd3;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_edge.sv
module irqc_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise_sel,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign hit[g] = rise_sel[g] ? (lvl[g] & ~prev_q[g]) : (~lvl[g] & prev_q[g]);
  end
endmodule

// File: rtl/irqc_resolve.sv
module irqc_resolve #(
  parameter int N = 5
) (
  input  logic [N-1:0] flag,
  input  logic [N-1:0] en,
  input  logic [N-1:0] prio_hi,
  input  logic         gie_h,
  input  logic         gie_l,
  input  logic         hp_active,
  input  logic         sleeping,
  output logic         irq_hi,
  output logic         irq_lo,
  output logic         wake
);
  logic [N-1:0] pend;
  logic [N-1:0] pend_hi;
  logic [N-1:0] pend_lo;

  for (genvar g = 0; g < N; g++) begin : g_src
    assign pend[g]    = flag[g] & en[g];
    assign pend_hi[g] = pend[g] & prio_hi[g];
    assign pend_lo[g] = pend[g] & ~prio_hi[g];
  end

  assign irq_hi = gie_h & (|pend_hi);
  assign irq_lo = gie_h & gie_l & ~hp_active & (|pend_lo);
  assign wake   = sleeping & (|pend);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int PORT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EXT_N-1:0]  ext_pin,
  input  logic [PORT_W-1:0] port_in,
  input  logic              tmr_wrap8,
  input  logic              tmr_wrap16,
  input  logic              tmr_wide,
  input  logic              sleeping,
  input  logic              hp_active,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              irq_hi,
  output logic              irq_lo,
  output logic              wake
);
  localparam int PIN_W = EXT_N + PORT_W;

  // synchronised inputs
  logic [PIN_W-1:0]  pins_s;
  logic [EXT_N-1:0]  ext_s;
  logic [PORT_W-1:0] port_s;
  logic [EXT_N-1:0]  ext_hit;

  // state
  logic [SRC_N-1:0]  flag_q, flag_d;
  logic [SRC_N-1:0]  en_q, en_d;
  logic [EXT_N-1:0]  edge_sel_q, edge_sel_d;
  logic              gie_h_q, gie_h_d, gie_l_q, gie_l_d;
  logic              p_port_q, p_port_d, p_tmr_q, p_tmr_d;
  logic              p_x1_q, p_x1_d, p_x2_q, p_x2_d;
  logic [PORT_W-1:0] snap_q, snap_d;

  logic [SRC_N-1:0]  evt;
  logic [SRC_N-1:0]  prio_hi;
  logic              wr_main, wr_cfg, wr_ext, rd_port, cfg_ce;

  irqc_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({port_in, ext_pin}),
    .dout (pins_s)
  );

  assign ext_s  = pins_s[EXT_N-1:0];
  assign port_s = pins_s[PIN_W-1:EXT_N];

  irqc_edge #(.W(EXT_N)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (ext_s),
    .rise_sel(edge_sel_q),
    .hit     (ext_hit)
  );

  // event vector
  always_comb begin
    evt           = '0;
    evt[SRC_PORT] = |(port_s ^ snap_q);
    evt[SRC_TMR]  = tmr_wide ? tmr_wrap16 : tmr_wrap8;
    evt[SRC_X0]   = ext_hit[0];
    evt[SRC_X1]   = ext_hit[1];
    evt[SRC_X2]   = ext_hit[2];
  end

  assign wr_main = reg_we && (reg_addr == A_MAIN);
  assign wr_cfg  = reg_we && (reg_addr == A_CFG);
  assign wr_ext  = reg_we && (reg_addr == A_EXT);
  assign rd_port = reg_re && (reg_addr == A_PORT);
  assign cfg_ce  = wr_main | wr_cfg | wr_ext;

  // next state
  always_comb begin
    flag_d     = flag_q;
    en_d       = en_q;
    edge_sel_d = edge_sel_q;
    gie_h_d    = gie_h_q;
    gie_l_d    = gie_l_q;
    p_port_d   = p_port_q;
    p_tmr_d    = p_tmr_q;
    p_x1_d     = p_x1_q;
    p_x2_d     = p_x2_q;
    if (wr_main) begin
      gie_h_d           = reg_wdata[7];
      gie_l_d           = reg_wdata[6];
      en_d[SRC_TMR]     = reg_wdata[5];
      en_d[SRC_X0]      = reg_wdata[4];
      en_d[SRC_PORT]    = reg_wdata[3];
      flag_d[SRC_TMR]   = reg_wdata[2];
      flag_d[SRC_X0]    = reg_wdata[1];
      flag_d[SRC_PORT]  = reg_wdata[0];
    end
    if (wr_cfg) begin
      edge_sel_d = reg_wdata[6:4];
      p_tmr_d    = reg_wdata[2];
      p_port_d   = reg_wdata[0];
    end
    if (wr_ext) begin
      p_x2_d          = reg_wdata[7];
      p_x1_d          = reg_wdata[6];
      en_d[SRC_X2]    = reg_wdata[4];
      en_d[SRC_X1]    = reg_wdata[3];
      flag_d[SRC_X2]  = reg_wdata[1];
      flag_d[SRC_X1]  = reg_wdata[0];
    end
    // a hardware event wins over a software clear
    flag_d = flag_d | evt;
    snap_d = port_s;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= '0;
      edge_sel_q <= '0;
      gie_h_q    <= 1'b0;
      gie_l_q    <= 1'b0;
      p_port_q   <= 1'b0;
      p_tmr_q    <= 1'b0;
      p_x1_q     <= 1'b0;
      p_x2_q     <= 1'b0;
    end else if (cfg_ce) begin
      en_q       <= en_d;
      edge_sel_q <= edge_sel_d;
      gie_h_q    <= gie_h_d;
      gie_l_q    <= gie_l_d;
      p_port_q   <= p_port_d;
      p_tmr_q    <= p_tmr_d;
      p_x1_q     <= p_x1_d;
      p_x2_q     <= p_x2_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (rd_port) snap_q <= snap_d;
  end

  // priority vector: pin 0 is wired high
  always_comb begin
    prio_hi           = '0;
    prio_hi[SRC_PORT] = p_port_q;
    prio_hi[SRC_TMR]  = p_tmr_q;
    prio_hi[SRC_X0]   = 1'b1;
    prio_hi[SRC_X1]   = p_x1_q;
    prio_hi[SRC_X2]   = p_x2_q;
  end

  irqc_resolve #(.N(SRC_N)) u_resolve (
    .flag     (flag_q),
    .en       (en_q),
    .prio_hi  (prio_hi),
    .gie_h    (gie_h_q),
    .gie_l    (gie_l_q),
    .hp_active(hp_active),
    .sleeping (sleeping),
    .irq_hi   (irq_hi),
    .irq_lo   (irq_lo),
    .wake     (wake)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MAIN: reg_rdata = {gie_h_q, gie_l_q, en_q[SRC_TMR], en_q[SRC_X0], en_q[SRC_PORT],
                           flag_q[SRC_TMR], flag_q[SRC_X0], flag_q[SRC_PORT]};
      A_CFG:  reg_rdata = {1'b0, edge_sel_q, 1'b0, p_tmr_q, 1'b0, p_port_q};
      A_EXT:  reg_rdata = {p_x2_q, p_x1_q, 1'b0, en_q[SRC_X2], en_q[SRC_X1], 1'b0,
                           flag_q[SRC_X2], flag_q[SRC_X1]};
      default: reg_rdata[REG_DW-1 -: PORT_W] = port_s;
    endcase
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic              wdata_b0,
  input logic              sleeping,
  input logic              hp_active,
  input logic              irq_hi,
  input logic              irq_lo,
  input logic              wake,
  input logic              flag_x0,
  input logic              flag_x1,
  input logic [SRC_N-1:0]  en,
  input logic              gie_h,
  input logic              evt_x1
);
  // R2: a set flag holds until its register is written
  assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_x0 && !(reg_we && reg_addr == A_MAIN)) |=> flag_x0);

  // R3: clear and event in one cycle leave the flag set
  assert_clear_collide_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_EXT && !wdata_b0 && evt_x1) |=> flag_x1);

  // R4: nothing enabled, nothing requested
  assert_all_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !(irq_hi || irq_lo || wake));

  // R5: pin 0 pending with the global enable always yields the high request
  assert_pin0_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_x0 && en[SRC_X0] && gie_h) |-> irq_hi);

  // R9: low requests are masked during high service
  assert_hp_masks_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hp_active |-> !irq_lo);

  // R10: wake only while asleep
  assert_wake_asleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sleeping |-> !wake);
endmodule

bind prio_irq_ctrl irqc_checker u_irqc_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .wdata_b0 (reg_wdata[0]),
  .sleeping (sleeping),
  .hp_active(hp_active),
  .irq_hi   (irq_hi),
  .irq_lo   (irq_lo),
  .wake     (wake),
  .flag_x0  (flag_q[irqc_pkg::SRC_X0]),
  .flag_x1  (flag_q[irqc_pkg::SRC_X1]),
  .en       (en_q),
  .gie_h    (gie_h_q),
  .evt_x1   (evt[irqc_pkg::SRC_X1])
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] ext_pin;
  logic [3:0] port_in;
  logic       tmr_wrap8, tmr_wrap16, tmr_wide;
  logic       sleeping, hp_active;
  logic       reg_we, reg_re;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq_hi, irq_lo, wake;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_in(port_in),
    .tmr_wrap8(tmr_wrap8), .tmr_wrap16(tmr_wrap16), .tmr_wide(tmr_wide),
    .sleeping(sleeping), .hp_active(hp_active),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_hi(irq_hi), .irq_lo(irq_lo), .wake(wake)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h, expected %h", tag, act, exp);
    end
  endtask

  task automatic outs(input string tag, input logic h, input logic l, input logic w);
    #1;
    chk({tag, " irq_hi"}, {7'd0, irq_hi}, {7'd0, h});
    chk({tag, " irq_lo"}, {7'd0, irq_lo}, {7'd0, l});
    chk({tag, " wake"},   {7'd0, wake},   {7'd0, w});
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ext_pin = '0; port_in = '0; tmr_wrap8 = 0; tmr_wrap16 = 0; tmr_wide = 0;
    sleeping = 0; hp_active = 0; reg_we = 0; reg_re = 0; reg_addr = '0; reg_wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  // side-effect-free look at registers 0..2, at the current time
  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic rd_port(output logic [7:0] v);
    @(negedge clk);
    reg_re = 1; reg_addr = 2'd3;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_re = 0;
  endtask

  task automatic set_pin(input int i, input logic v);
    @(negedge clk);
    ext_pin[i] = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    peek(2'd0, v); chk("R11 reg0", v, 8'h00);
    peek(2'd1, v); chk("R11 reg1", v, 8'h00);
    peek(2'd2, v); chk("R11 reg2", v, 8'h00);
    outs("R11", 0, 0, 0);
  endtask

  task automatic t_edges();
    logic [7:0] v;
    do_reset();
    // pin0 falling-edge mode: rising must not set the flag
    set_pin(0, 1'b1);
    peek(2'd0, v); chk("R1 rise ignored in falling mode", v, 8'h00);
    @(negedge clk);
    ext_pin[0] = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    peek(2'd0, v); chk("R1 flag not yet after 2 edges", v, 8'h00);
    @(negedge clk);
    peek(2'd0, v); chk("R1 falling edge sets pin0 flag", v, 8'h02);
    // pin1 rising mode
    wr(2'd1, 8'h20);
    set_pin(1, 1'b1);
    peek(2'd2, v); chk("R1 rising edge sets pin1 flag", v, 8'h01);
    set_pin(1, 1'b0);
    wr(2'd2, 8'h00);
    repeat (4) @(negedge clk);
    peek(2'd2, v); chk("R1 falling ignored in rising mode", v, 8'h00);
  endtask

  task automatic t_sticky();
    logic [7:0] v;
    do_reset();
    wr(2'd2, 8'h01);
    repeat (6) @(negedge clk);
    peek(2'd2, v); chk("R2 software set stays", v, 8'h01);
    wr(2'd2, 8'h00);
    peek(2'd2, v); chk("R2 write 0 clears", v, 8'h00);
  endtask

  task automatic t_disabled_and_pin0();
    logic [7:0] v;
    do_reset();
    wr(2'd0, 8'hC2);               // globals on, pin0 flag, pin0 disabled
    peek(2'd0, v); chk("R4 flag recorded while disabled", v, 8'hC2);
    outs("R4 disabled", 0, 0, 0);
    wr(2'd0, 8'hD2);               // enable pin0
    outs("R5 pin0 high", 1, 0, 0);
    wr(2'd1, 8'h00);               // no priority bit exists for pin0
    wr(2'd2, 8'h00);
    outs("R5 pin0 still high", 1, 0, 0);
  endtask

  task automatic t_prio_bits();
    do_reset();
    wr(2'd0, 8'hC0);
    wr(2'd2, 8'h09); outs("R6 pin1 low prio",  0, 1, 0);
    wr(2'd2, 8'h49); outs("R6 pin1 high prio", 1, 0, 0);
    wr(2'd2, 8'h92); outs("R6 pin2 high prio", 1, 0, 0);
    wr(2'd2, 8'h12); outs("R6 pin2 low prio",  0, 1, 0);
  endtask

  task automatic t_mask();
    do_reset();
    wr(2'd0, 8'hC0);
    wr(2'd2, 8'h09);
    outs("R9 low request", 0, 1, 0);
    @(negedge clk); hp_active = 1;
    outs("R9 masked by hp_active", 0, 0, 0);
    @(negedge clk); hp_active = 0;
    wr(2'd0, 8'h80); outs("R9 low enable off", 0, 0, 0);
    wr(2'd0, 8'h40); outs("R9 high enable off", 0, 0, 0);
  endtask

  task automatic pulse(input logic w16);
    @(negedge clk);
    if (w16) tmr_wrap16 = 1; else tmr_wrap8 = 1;
    @(negedge clk);
    tmr_wrap16 = 0; tmr_wrap8 = 0;
  endtask

  task automatic t_timer();
    logic [7:0] v;
    do_reset();
    pulse(1'b1); peek(2'd0, v); chk("R7 8-bit mode ignores 16-bit wrap", v, 8'h00);
    pulse(1'b0); peek(2'd0, v); chk("R7 8-bit wrap sets flag", v, 8'h04);
    wr(2'd0, 8'h00);
    @(negedge clk); tmr_wide = 1;
    pulse(1'b0); peek(2'd0, v); chk("R7 16-bit mode ignores 8-bit wrap", v, 8'h00);
    pulse(1'b1); peek(2'd0, v); chk("R7 16-bit wrap sets flag", v, 8'h04);
    wr(2'd1, 8'h04);
    wr(2'd0, 8'hA4);
    outs("R7 timer high prio", 1, 0, 0);
  endtask

  task automatic t_port();
    logic [7:0] v;
    do_reset();
    @(negedge clk); port_in = 4'b0101;
    repeat (3) @(posedge clk);
    @(negedge clk);
    peek(2'd0, v); chk("R8 change sets flag", v, 8'h01);
    rd_port(v); chk("R8 port read value", v, 8'h50);
    wr(2'd0, 8'h00);
    repeat (3) @(negedge clk);
    peek(2'd0, v); chk("R8 clear holds after snapshot", v, 8'h00);
    @(negedge clk); port_in = 4'b0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    peek(2'd0, v); chk("R8 second change sets flag", v, 8'h01);
    wr(2'd0, 8'h00);
    peek(2'd0, v); chk("R8 mismatch re-sets flag without read", v, 8'h01);
    wr(2'd0, 8'hC9);
    outs("R8 port low prio", 0, 1, 0);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    do_reset();
    wr(2'd1, 8'h20);
    wr(2'd2, 8'h01);
    @(negedge clk); ext_pin[1] = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_we = 1; reg_addr = 2'd2; reg_wdata = 8'h00;
    @(negedge clk); reg_we = 0;
    peek(2'd2, v); chk("R3 clear and edge together keep flag", v, 8'h01);
    wr(2'd2, 8'h00);
    peek(2'd2, v); chk("R3 plain clear afterwards", v, 8'h00);
  endtask

  task automatic t_wake();
    do_reset();
    wr(2'd0, 8'h12);               // pin0 enabled + flag, globals off
    @(negedge clk); sleeping = 1;
    outs("R10 wake with globals off", 0, 0, 1);
    @(negedge clk); sleeping = 0;
    outs("R10 awake drops wake", 0, 0, 0);
    wr(2'd0, 8'h02);
    @(negedge clk); sleeping = 1;
    outs("R10 disabled source no wake", 0, 0, 0);
    @(negedge clk); sleeping = 0;
  endtask

  initial begin
    t_reset();
    t_edges();
    t_sticky();
    t_disabled_and_pin0();
    t_prio_bits();
    t_mask();
    t_timer();
    t_port();
    t_collision();
    t_wake();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule